// File: doc/BRIEF.md
# Compressed Branch Trace Output Port

This block streams the destination address of every taken branch of a processor core onto a narrow trace bus: a 4-bit data nibble and a sync strobe, both timed by an external trace clock. Branches and interrupt or exception entries look alike to the block. The core reports each one with a one-cycle pulse and a 32-bit destination. A one-entry holding register in the core clock domain keeps the newest event. A toggle handshake then carries it into the trace clock domain. The trace clock must run at no more than a quarter of the core clock.

The block does not send the full address each time. It compares the new destination with the last address whose transfer finished. It sends only the smallest low-order slice (4, 8, 16 or 32 bits) above which both addresses agree. A header nibble names the slice length. When nothing is pending, a fixed idle nibble fills the bus. A newer branch cuts off a transfer in progress and starts its own transfer at once.

Branch trace operation is selected by holding the mode pin low while the trace reset is asserted, then releasing the reset.

Top module: `branch_trace_port`

## Requirements
- R1: The mode pin is captured while `trst_ni` is low. If it is high when the reset is released, the bus stays at 0011 with the strobe low and branches are ignored until the next trace reset.
- R2: After trace reset, and whenever no transfer is in progress, `tdata_o` shows 0011 and `tsync_o` is low on every trace clock.
- R3: A branch pulse produces exactly one transfer, in issue order, provided branches are at least three trace clocks apart. A transfer is one header cycle followed by 1, 2, 4 or 8 address cycles.
- R4: The header lasts one trace clock with the strobe low. It is 1000 for 4 bits, 1001 for 8, 1010 for 16 and 1011 for 32. The length is the smallest of these for which every destination bit at or above it equals the same bit of the reference address.
- R5: Address nibbles follow the header one per trace clock, least significant nibble first, with `tsync_o` high for each of them.
- R6: On the trace clock after the final address nibble, `tsync_o` drops and 0011 appears in the same cycle.
- R7: The reference address is 0x00000000 after trace reset. It takes the value of a destination only when that destination's final nibble has been sent. An aborted transfer leaves it unchanged.
- R8: A branch arriving during a header or address cycle takes over the bus. The strobe drops and a fresh header for the new destination appears, sized against the unchanged reference.
- R9: A new branch whose header lands in the cycle right after a final nibble does not abort that transfer. The finished address becomes the reference, and the new header is sized against it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Core-domain reset, active low |
| br_valid_i | input | 1 | One-cycle pulse: branch or exception entry taken |
| br_addr_i | input | 32 | Destination address, valid with `br_valid_i` |
| tck_i | input | 1 | External trace clock, at most a quarter of `clk_i` |
| trst_ni | input | 1 | Trace reset, active low |
| mode_i | input | 1 | Operating mode select, low picks branch trace, sampled during trace reset |
| tdata_o | output | 4 | Trace data nibble: idle code, header or address nibble |
| tsync_o | output | 1 | High while address nibbles are on the bus |

## Verification
Directed destinations are chosen to differ from the reference in only the lowest nibble, the second nibble, the upper half of the low word, or the top half. These select each of the four header codes, and the all-equal case selects the shortest form. A pair of branches three trace clocks apart lands the second header exactly on the completion cycle, which separates R9 from an abort. A pair five clocks apart cuts a 32-bit transfer short. The size of the next header then shows whether the reference moved. Random destinations that flip bits inside a random slice, issued at random spacing, mix complete and aborted transfers. The decoded stream is compared nibble by nibble with a reference model. A disabled-mode run, and a re-enable whose first header is sized against zero, cover mode capture and reference reset.

// File: rtl/bt_pkg.sv
package bt_pkg;
   localparam int unsigned NIB_W = 4;
   localparam logic [NIB_W-1:0] IDLE_NIB = 4'b0011;
   localparam logic [1:0] HDR_TAG = 2'b10;

   // length class, also the low two bits of the header nibble
   typedef enum logic [1:0] {
      LEN4  = 2'b00,
      LEN8  = 2'b01,
      LEN16 = 2'b10,
      LEN32 = 2'b11
   } len_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_HDR  = 2'b01,
      ST_DATA = 2'b10
   } st_e;

   // index of the final nibble for a length class
   function automatic int unsigned last_nib(len_e l);
      return (32'd1 << l) - 32'd1;
   endfunction
endpackage

// File: rtl/bt_event_cdc.sv
module bt_event_cdc #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              br_valid_i,
   input  logic [ADDR_W-1:0] br_addr_i,
   input  logic              tck_i,
   output logic              ev_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] hold_q;
   logic              tog_q;

   // one-entry holding register: a newer event overwrites the older one
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_q <= '0;
         tog_q  <= 1'b0;
      end else if (br_valid_i) begin
         hold_q <= br_addr_i;
         tog_q  <= ~tog_q;
      end
   end

   // synchronizer stages plus one edge-detect stage, left without reset
   // so the chain settles to the toggle level while trace reset is held
   logic [SYNC_STAGES:0] chain_q;

   for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge tck_i) chain_q[s] <= tog_q;
      end else begin : g_next
         always_ff @(posedge tck_i) chain_q[s] <= chain_q[s-1];
      end
   end

   assign ev_o   = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];
   assign addr_o = hold_q;
endmodule

// File: rtl/bt_len_sel.sv
module bt_len_sel
   import bt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:4] new_hi_i,
   input  logic [ADDR_W-1:4] ref_hi_i,
   output len_e              len_o
);
   localparam int unsigned B8  = 4;
   localparam int unsigned B16 = 8;
   localparam int unsigned B32 = 16;

   logic [ADDR_W-1:4] diff;
   assign diff = new_hi_i ^ ref_hi_i;

   always_comb begin
      if (|diff[ADDR_W-1:B32])    len_o = LEN32;
      else if (|diff[B32-1:B16])  len_o = LEN16;
      else if (|diff[B16-1:B8])   len_o = LEN8;
      else                        len_o = LEN4;
   end
endmodule

// File: rtl/bt_serializer.sv
module bt_serializer
   import bt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              tck_i,
   input  logic              trst_ni,
   input  logic              en_i,
   input  logic              ev_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NIB_W-1:0]  tdata_o,
   output logic              tsync_o,
   output logic [ADDR_W-1:0] ref_o
);
   localparam int unsigned NIBS  = ADDR_W / NIB_W;
   localparam int unsigned IDX_W = $clog2(NIBS);

   st_e               st_q;
   logic [IDX_W-1:0]  idx_q, last_q, idx_nx;
   logic [ADDR_W-1:0] cur_q, ref_q, ref_eff;
   logic [NIB_W-1:0]  data_q, nib_nx;
   logic              sync_q, done_now;
   len_e              len;

   // the final nibble has been on the bus for a full clock at this edge
   assign done_now = (st_q == ST_DATA) && (idx_q == last_q);
   assign ref_eff  = done_now ? cur_q : ref_q;
   assign idx_nx   = idx_q + 1'b1;
   assign nib_nx   = NIB_W'(cur_q >> {idx_nx, 2'b00});

   bt_len_sel #(.ADDR_W(ADDR_W)) i_len (
      .new_hi_i (addr_i[ADDR_W-1:4]),
      .ref_hi_i (ref_eff[ADDR_W-1:4]),
      .len_o    (len)
   );

   always_ff @(posedge tck_i or negedge trst_ni) begin
      if (!trst_ni) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         last_q <= '0;
         cur_q  <= '0;
         ref_q  <= '0;
         data_q <= IDLE_NIB;
         sync_q <= 1'b0;
      end else if (!en_i) begin
         st_q   <= ST_IDLE;
         data_q <= IDLE_NIB;
         sync_q <= 1'b0;
      end else begin
         if (done_now) ref_q <= cur_q;
         if (ev_i) begin
            // newest branch wins, whatever is on the bus
            st_q   <= ST_HDR;
            cur_q  <= addr_i;
            idx_q  <= '0;
            last_q <= IDX_W'(last_nib(len));
            data_q <= {HDR_TAG, len};
            sync_q <= 1'b0;
         end else begin
            unique case (st_q)
               ST_HDR: begin
                  st_q   <= ST_DATA;
                  idx_q  <= '0;
                  data_q <= cur_q[NIB_W-1:0];
                  sync_q <= 1'b1;
               end
               ST_DATA: begin
                  if (done_now) begin
                     st_q   <= ST_IDLE;
                     data_q <= IDLE_NIB;
                     sync_q <= 1'b0;
                  end else begin
                     idx_q  <= idx_nx;
                     data_q <= nib_nx;
                  end
               end
               default: begin
                  st_q   <= ST_IDLE;
                  data_q <= IDLE_NIB;
                  sync_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign tdata_o = data_q;
   assign tsync_o = sync_q;
   assign ref_o   = ref_q;
endmodule

// File: rtl/branch_trace_port.sv
module branch_trace_port #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              br_valid_i,
   input  logic [ADDR_W-1:0] br_addr_i,
   input  logic              tck_i,
   input  logic              trst_ni,
   input  logic              mode_i,
   output logic [3:0]        tdata_o,
   output logic              tsync_o
);
   if (ADDR_W != 32) begin : g_bad_addr_w
      initial $fatal(1, "branch_trace_port: header classes need ADDR_W of 32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "branch_trace_port: SYNC_STAGES must be at least 2");
   end

   logic              ev;
   logic [ADDR_W-1:0] ev_addr;
   logic [ADDR_W-1:0] ref_addr;
   logic              trace_en_q;

   // mode capture: follows the pin while trace reset is held, frozen after
   always_ff @(posedge tck_i) begin
      if (!trst_ni) trace_en_q <= ~mode_i;
   end

   bt_event_cdc #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_cdc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .br_valid_i (br_valid_i),
      .br_addr_i  (br_addr_i),
      .tck_i      (tck_i),
      .ev_o       (ev),
      .addr_o     (ev_addr)
   );

   bt_serializer #(.ADDR_W(ADDR_W)) i_ser (
      .tck_i   (tck_i),
      .trst_ni (trst_ni),
      .en_i    (trace_en_q),
      .ev_i    (ev),
      .addr_i  (ev_addr),
      .tdata_o (tdata_o),
      .tsync_o (tsync_o),
      .ref_o   (ref_addr)
   );
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              tck_i,
   input logic              trst_ni,
   input logic              en_i,
   input logic [3:0]        tdata_i,
   input logic              tsync_i,
   input logic [ADDR_W-1:0] ref_i
);
   logic [3:0] run_q;

   always_ff @(posedge tck_i or negedge trst_ni) begin
      if (!trst_ni)     run_q <= '0;
      else if (tsync_i) run_q <= run_q + 4'd1;
      else              run_q <= '0;
   end

   p_idle_or_hdr_r2: assert property (@(posedge tck_i) disable iff (!trst_ni)
      !tsync_i |-> (tdata_i == 4'b0011 || tdata_i[3:2] == 2'b10));

   p_off_idle_r1: assert property (@(posedge tck_i) disable iff (!trst_ni)
      !en_i |-> (tdata_i == 4'b0011 && !tsync_i));

   p_hdr_then_addr_r5: assert property (@(posedge tck_i) disable iff (!trst_ni)
      (!tsync_i && tdata_i[3:2] == 2'b10) |=> (tsync_i || tdata_i[3:2] == 2'b10));

   p_end_idle_r6: assert property (@(posedge tck_i) disable iff (!trst_ni)
      $fell(tsync_i) |-> (tdata_i == 4'b0011 || tdata_i[3:2] == 2'b10));

   p_ref_on_finish_r7: assert property (@(posedge tck_i) disable iff (!trst_ni)
      !$stable(ref_i) |-> $fell(tsync_i));

   p_run_len_r3: assert property (@(posedge tck_i) disable iff (!trst_ni)
      tsync_i |-> (run_q < 4'd8));
endmodule

bind branch_trace_port bt_checker #(.ADDR_W(ADDR_W)) i_chk (
   .tck_i   (tck_i),
   .trst_ni (trst_ni),
   .en_i    (trace_en_q),
   .tdata_i (tdata_o),
   .tsync_i (tsync_o),
   .ref_i   (ref_addr)
);

// File: tb/test_branch_trace_port.sv
`timescale 1ns/1ps
module test_branch_trace_port;
   logic        clk = 1'b0, tck = 1'b0;
   logic        rst_n, trst_n, mode, br_valid;
   logic [31:0] br_addr;
   logic [3:0]  tdata;
   logic        tsync;

   int checks = 0, errors = 0;
   int n_done = 0, n_abort = 0, n_edge = 0;
   bit mon_en = 1'b0;
   bit in_xfer = 1'b0;
   int got = 0, need = 0;
   logic [31:0] cur_m = '0, ref_m = '0, last_a = '0;
   logic [31:0] exp_q[$];

   always #2.5 clk = ~clk;
   initial begin #3; forever #10 tck = ~tck; end

   branch_trace_port i_branch_trace_port (
      .clk_i(clk), .rst_ni(rst_n), .br_valid_i(br_valid), .br_addr_i(br_addr),
      .tck_i(tck), .trst_ni(trst_n), .mode_i(mode),
      .tdata_o(tdata), .tsync_o(tsync));

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] hdr_of(logic [31:0] a, logic [31:0] r);
      logic [31:0] d = a ^ r;
      if (d[31:16] != 0) return 4'b1011;
      if (d[15:8] != 0)  return 4'b1010;
      if (d[7:4] != 0)   return 4'b1001;
      return 4'b1000;
   endfunction

   // stream decoder and reference model
   always @(negedge tck) begin
      if (mon_en && trst_n) begin
         if (!tsync && tdata[3:2] == 2'b10) begin
            if (in_xfer) begin
               if (need != 0 && got == need) begin ref_m = cur_m; n_done++; n_edge++; end // R9
               else n_abort++;                                                          // R8
            end
            in_xfer = 1'b1; got = 0; need = 0;
            if (exp_q.size() == 0) check(1'b0, "R3 header without branch", {28'd0, tdata}, 32'd0);
            else begin
               logic [3:0] h;
               cur_m = exp_q.pop_front();
               h = hdr_of(cur_m, ref_m);
               need = 1 << h[1:0];
               check(tdata == h, "R4 header code", {28'd0, tdata}, {28'd0, h});
            end
         end else if (tsync) begin
            if (!in_xfer || got >= need) check(1'b0, "R5 stray address nibble", got, need);
            else begin
               check(tdata == cur_m[got*4 +: 4], "R5 address nibble", {28'd0, tdata}, {28'd0, cur_m[got*4 +: 4]});
               got++;
            end
         end else if (tdata == 4'b0011) begin
            if (in_xfer) begin
               check(got == need, "R6 idle after final nibble", got, need);
               if (got == need) begin ref_m = cur_m; n_done++; end   // R7 update
               in_xfer = 1'b0;
            end
         end else check(1'b0, "R2 illegal nibble", {28'd0, tdata}, 32'h3);
      end
   end

   task automatic branch(logic [31:0] a, int gap, bit track);
      @(negedge clk);
      br_valid = 1'b1; br_addr = a;
      if (track) exp_q.push_back(a);
      @(negedge clk);
      br_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
   endtask

   task automatic wait_quiet();
      while (exp_q.size() != 0 || in_xfer) @(negedge tck);
      repeat (4) @(negedge tck);
   endtask

   task automatic trace_reset(bit m);
      @(negedge tck); trst_n = 1'b0; mode = m;
      repeat (5) @(negedge tck);
      trst_n = 1'b1;
      @(negedge tck);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; trst_n = 1'b0; mode = 1'b0; br_valid = 1'b0; br_addr = '0;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      trace_reset(1'b0);

      // R2: reset state is idle
      begin
         int bad = 0;
         repeat (8) begin @(negedge tck); if (tdata != 4'b0011 || tsync) bad++; end
         check(bad == 0, "R2 idle after reset", bad, 0);
      end
      mon_en = 1'b1;

      // R4/R7: each length class against reference 0, then a repeat
      branch(32'h0000_0005, 60, 1);
      branch(32'h0000_0035, 60, 1);
      branch(32'h0000_1235, 60, 1);
      branch(32'h8000_1235, 60, 1);
      branch(32'h8000_1235, 60, 1);
      wait_quiet();

      // R8: 32-bit transfer cut short; next header sized against old reference
      begin
         int ab = n_abort;
         branch(32'h0000_1235, 20, 1);   // vs 0x80001235: 32 bits, aborted
         branch(32'h8000_1234, 60, 1);   // vs unchanged ref: 4 bits
         wait_quiet();
         check(n_abort == ab + 1, "R8 abort observed", n_abort, ab + 1);
      end

      // R9: second header lands on the completion cycle of an 8-bit transfer
      begin
         int ed = n_edge;
         branch(32'h8000_1204, 12, 1);   // vs 0x80001234: 8 bits
         branch(32'h8000_1204, 60, 1);   // vs finished address: 4 bits
         wait_quiet();
         check(n_edge == ed + 1, "R9 completion on header edge", n_edge, ed + 1);
      end

      // R3/R4/R5/R8: random slices and spacing
      last_a = 32'h8000_1204;
      for (int i = 0; i < 300; i++) begin
         int k = $urandom % 4;
         logic [31:0] m = (k == 0) ? 32'hF : (k == 1) ? 32'hFF : (k == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
         last_a = last_a ^ ($urandom & m);
         branch(last_a, 16 + ($urandom % 55), 1);
      end
      wait_quiet();
      check(exp_q.size() == 0, "R3 every branch transferred", exp_q.size(), 0);
      check(n_abort > 1, "R8 random aborts seen", n_abort, 2);
      check(n_done > 100, "R6 random completions seen", n_done, 101);

      // R1: mode high during trace reset disables the port
      mon_en = 1'b0;
      trace_reset(1'b1);
      begin
         int bad = 0;
         fork
            for (int i = 0; i < 5; i++) branch(32'h1234_5678 + i, 40, 0);
            repeat (80) begin @(negedge tck); if (tdata != 4'b0011 || tsync) bad++; end
         join
         check(bad == 0, "R1 disabled port stays idle", bad, 0);
      end

      // R7: re-enable; reference is back to zero
      trace_reset(1'b0);
      ref_m = '0; in_xfer = 1'b0; got = 0; need = 0;
      mon_en = 1'b1;
      branch(32'h0000_0010, 60, 1);      // vs 0: 8 bits, header 1001
      wait_quiet();
      check(exp_q.size() == 0 && !in_xfer, "R7 transfer after re-enable", exp_q.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule